// File: doc/BRIEF.md
# Two-Wire Write-Only DAC Code Receiver

This block is the digital front end of an 8-bit voltage DAC that is programmed over a two-wire I2C bus. It samples the raw SCL and SDA lines with a faster system clock and cleans them through synchronizers and a majority filter. It finds START, repeated START and STOP conditions and decodes bus transactions that write to it. It acknowledges each byte it accepts by enabling an open-drain pull-down on SDA.

The block answers to two write addresses. The first is its own address: a fixed six-bit prefix followed by a select bit taken from a pin. The second is a broadcast address that every copy answers. After the address, the master sends two-byte frames. Each frame carries a new conversion code and a two-bit power-down selection. The master may send as many frames as it likes in one transaction. Both registers load together at the end of each frame, and a one-cycle strobe marks each load.

The block also recognizes the high-speed master code and raises a flag while the bus runs in high-speed mode. The analog side reads the code, the power-down selection and the strobe.

Top module: `i2c_dac_ctl`

## Requirements
- R1: After reset the code output is 0x00, the power-down output is 00, the SDA pull-down is off and the high-speed flag is low.
- R2: A write to address 1,0,0,1,1,0,S is acknowledged, where S is the value of `addr_sel` on the first clock after reset. Later changes of `addr_sel` have no effect.
- R3: A write to broadcast address 1001000 is acknowledged whatever S is.
- R4: Some address bytes are not acknowledged: a read (LSB = 1), a foreign address, the general call 0x00, or a 10-bit prefix 11110xx. For any of these, every further byte up to the next START or STOP is ignored: no acknowledge and no update.
- R5: For an accepted byte, the pull-down turns on while SCL is low after the eighth data bit. It stays on through the high phase of the ninth pulse and turns off after that pulse falls.
- R6: First frame byte: bits 5:4 are the power-down mode, bits 3:0 are code bits 7..4, and bits 7:6 are ignored. Second frame byte: bits 7:4 are code bits 3..0, and bits 3:0 are ignored.
- R7: Code and mode change only together with a one-cycle `update_pulse`. This happens after the falling SCL edge that ends the acknowledge of the second frame byte, never earlier.
- R8: Several frames in one transaction, with no new address, each produce their own update.
- R9: A repeated START returns to the address phase and discards a half-received frame.
- R10: The byte 00001xxx in the address slot is not acknowledged and sets `hs_active`. A STOP clears it, and an address after a repeated START is then handled normally.
- R11: A nonzero power-down mode (01 = 1k pull-down, 10 = 100k pull-down, 11 = high impedance) leaves the written code on `dac_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Address select pin, sampled once after reset |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line (wired bus value) |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| dac_code | output | 8 | Current conversion code |
| pd_mode | output | 2 | Power-down selection (00 normal) |
| update_pulse | output | 1 | One-cycle strobe when code and mode load |
| hs_active | output | 1 | High-speed master code seen since last STOP |

## Verification
Frames are sent one per transaction, several back to back after a single address, and with the ignored bits of both bytes set. These patterns separate a correct frame assembly from one that keeps stale bytes or reads the wrong field. Addresses are tried as the own address, before and after the select pin changes, as the broadcast address, as a read, as a foreign address, as the general call and as a 10-bit prefix. Together they show what gets an acknowledge and that rejected transactions never produce an update. A frame broken off by a repeated START, and the high-speed code followed by a repeated START, test the return to the address phase. A scoreboard pairs every expected load with exactly one strobe.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;
   localparam int BYTE_W = 8;
   localparam int CODE_W = 8;
   localparam int MODE_W = 2;
   localparam int NIB_W  = CODE_W / 2;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ADDR,
      PH_HI,
      PH_LO
   } phase_t;

   typedef enum logic [MODE_W-1:0] {
      PD_NORMAL   = 2'b00,
      PD_PULL_1K  = 2'b01,
      PD_PULL_100K = 2'b10,
      PD_HIZ      = 2'b11
   } pd_sel_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1 || (FILT_LEN % 2) == 0) begin : g_bad_filt
      $error("FILT_LEN must be odd and positive");
   end

   logic [SYNC_STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], raw};
   end

   if (FILT_LEN == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clean <= 1'b1;
         else        clean <= chain[SYNC_STAGES-1];
      end
   end else begin : g_vote
      logic [FILT_LEN-1:0] win;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win   <= '1;
            clean <= 1'b1;
         end else begin
            win   <= {win[FILT_LEN-2:0], chain[SYNC_STAGES-1]};
            clean <= ($countones(win) > (FILT_LEN / 2));
         end
      end
   end
endmodule

// File: rtl/bus_events.sv
module bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   always_comb begin
      scl_rise  = scl_f & ~scl_d;
      scl_fall  = ~scl_f & scl_d;
      start_evt = scl_f & scl_d & sda_d & ~sda_f;
      stop_evt  = scl_f & scl_d & ~sda_d & sda_f;
   end
endmodule

// File: rtl/frame_engine.sv
module frame_engine
   import dacctl_pkg::*;
#(
   parameter logic [5:0] DEV_PREFIX = 6'b100110,
   parameter logic [6:0] BCAST_ADDR = 7'b1001000,
   parameter logic [4:0] HS_TAG     = 5'b00001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_bit,
   input  logic              sda_f,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   output logic              pull_low,
   output logic [CODE_W-1:0] code_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              upd,
   output logic              hs_flag
);
   localparam int CNT_W = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);
   localparam int HOLD_W = MODE_W + NIB_W;

   phase_t               phase;
   logic [CNT_W-1:0]     bit_cnt;
   logic [BYTE_W-1:0]    shreg;
   logic [HOLD_W-1:0]    hi_hold;
   logic                 addr_hit, hs_code, byte_ok;

   always_comb begin
      addr_hit = !shreg[0] &&
                 ((shreg[7:1] == {DEV_PREFIX, sel_bit}) || (shreg[7:1] == BCAST_ADDR));
      hs_code  = (phase == PH_ADDR) && (shreg[7:3] == HS_TAG);
      byte_ok  = (phase == PH_ADDR) ? addr_hit : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         hi_hold  <= '0;
         pull_low <= 1'b0;
         code_q   <= '0;
         mode_q   <= PD_NORMAL;
         upd      <= 1'b0;
         hs_flag  <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (stop_evt) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            pull_low <= 1'b0;
            hs_flag  <= 1'b0;
         end else if (start_evt) begin
            phase    <= PH_ADDR;
            bit_cnt  <= '0;
            pull_low <= 1'b0;
         end else if (phase != PH_IDLE) begin
            if (scl_rise && bit_cnt < LAST_BIT) begin
               shreg   <= {shreg[BYTE_W-2:0], sda_f};
               bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
               if (byte_ok) begin
                  pull_low <= 1'b1;
                  bit_cnt  <= ACK_SLOT;
               end else begin
                  phase   <= PH_IDLE;
                  bit_cnt <= '0;
                  if (hs_code) hs_flag <= 1'b1;
               end
            end else if (scl_fall && bit_cnt == ACK_SLOT) begin
               pull_low <= 1'b0;
               bit_cnt  <= '0;
               case (phase)
                  PH_ADDR: phase <= PH_HI;
                  PH_HI: begin
                     hi_hold <= shreg[HOLD_W-1:0];
                     phase   <= PH_LO;
                  end
                  PH_LO: begin
                     code_q <= {hi_hold[NIB_W-1:0], shreg[BYTE_W-1 -: NIB_W]};
                     mode_q <= hi_hold[HOLD_W-1 -: MODE_W];
                     upd    <= 1'b1;
                     phase  <= PH_HI;
                  end
                  default: phase <= PH_IDLE;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/i2c_dac_ctl.sv
module i2c_dac_ctl
   import dacctl_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   parameter logic [5:0] DEV_PREFIX  = 6'b100110,
   parameter logic [6:0] BCAST_ADDR  = 7'b1001000,
   parameter logic [4:0] HS_TAG      = 5'b00001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_sel,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_drive_low,
   output logic [CODE_W-1:0] dac_code,
   output logic [MODE_W-1:0] pd_mode,
   output logic              update_pulse,
   output logic              hs_active
);
   localparam int N_LINES = 2;

   logic [N_LINES-1:0] raw_lines, clean_lines;
   logic scl_clean, sda_clean;
   logic scl_rise, scl_fall, start_evt, stop_evt;
   logic sel_q, sel_taken;

   assign raw_lines = {sda_in, scl_in};

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
         .clk(clk), .rst_n(rst_n), .raw(raw_lines[i]), .clean(clean_lines[i]));
   end

   assign scl_clean = clean_lines[0];
   assign sda_clean = clean_lines[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         sel_taken <= 1'b0;
      end else if (!sel_taken) begin
         sel_q     <= addr_sel;
         sel_taken <= 1'b1;
      end
   end

   bus_events u_evt (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_clean), .sda_f(sda_clean),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt));

   frame_engine #(.DEV_PREFIX(DEV_PREFIX), .BCAST_ADDR(BCAST_ADDR), .HS_TAG(HS_TAG)) u_eng (
      .clk(clk), .rst_n(rst_n), .sel_bit(sel_q), .sda_f(sda_clean),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .pull_low(sda_drive_low), .code_q(dac_code), .mode_q(pd_mode),
      .upd(update_pulse), .hs_flag(hs_active));
endmodule

// File: rtl/dacctl_checker.sv
module dacctl_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_f,
   input logic       stop_evt,
   input logic       sda_drive_low,
   input logic [7:0] dac_code,
   input logic [1:0] pd_mode,
   input logic       update_pulse,
   input logic       hs_active
);
   // R7
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_pulse |=> !update_pulse);
   // R7
   code_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_code != $past(dac_code)) |-> update_pulse);
   // R7
   mode_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode != $past(pd_mode)) |-> update_pulse);
   // R5
   pull_on_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> !scl_f);
   // R5
   pull_off_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_drive_low) |-> !scl_f);
   // R10
   stop_clears_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !hs_active);
endmodule

bind i2c_dac_ctl dacctl_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_clean), .stop_evt(stop_evt),
   .sda_drive_low(sda_drive_low), .dac_code(dac_code), .pd_mode(pd_mode),
   .update_pulse(update_pulse), .hs_active(hs_active));

// File: tb/i2c_dac_ctl_test.sv
module i2c_dac_ctl_test;
   localparam int Q = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_sel = 1'b1;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_drive_low, update_pulse, hs_active;
   logic [7:0] dac_code;
   logic [1:0] pd_mode;

   int compared = 0;
   int mismatched = 0;
   logic [9:0] expq[$];

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_drive_low;

   i2c_dac_ctl uut (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(scl_m), .sda_in(sda_bus),
      .sda_drive_low(sda_drive_low), .dac_code(dac_code), .pd_mode(pd_mode),
      .update_pulse(update_pulse), .hs_active(hs_active));

   task automatic check(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(2 * Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic want_ack, input string req);
      for (int i = 7; i >= 0; i--) begin
         tick(Q); sda_m = b[i];
         tick(Q); scl_m = 1'b1;
         tick(2 * Q); scl_m = 1'b0;
      end
      tick(Q); sda_m = 1'b1;
      tick(Q); scl_m = 1'b1;
      tick(Q);
      check(req, int'(!sda_bus), int'(want_ack));
      tick(Q); scl_m = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] code, input logic [1:0] mode,
                             input logic [1:0] top);
      send_byte({top, mode, code[7:4]}, 1'b1, "R6 first byte ack");
      expq.push_back({mode, code});
      send_byte({code[3:0], 4'hA}, 1'b1, "R6 second byte ack");
   endtask

   // scoreboard monitor: every strobe must match the oldest expected load (R7)
   always @(negedge clk) begin
      if (rst_n && update_pulse) begin
         if (expq.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL R7 unexpected update actual=%0h expected=none", {pd_mode, dac_code});
         end else begin
            check("R7 update value", int'({pd_mode, dac_code}), int'(expq.pop_front()));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      tick(10);
      rst_n = 1'b1;
      tick(5);
      // R1 reset state
      check("R1 code", int'(dac_code), 0);
      check("R1 mode", int'(pd_mode), 0);
      check("R1 pull", int'(sda_drive_low), 0);
      check("R1 hs", int'(hs_active), 0);

      // R2: select sampled as 1; changing pin afterwards has no effect
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'h9A, 1'b1, "R2 own address ack");
      send_frame(8'hA5, 2'b00, 2'b00);
      bus_stop();
      check("R2 code", int'(dac_code), 'hA5);

      // R8 several frames, R7 no change mid-frame, R11 power-down keeps code
      bus_start();
      send_byte(8'h9A, 1'b1, "R8 address ack");
      send_frame(8'h3C, 2'b00, 2'b00);
      send_byte(8'h0F, 1'b1, "R7 first byte ack");
      check("R7 code held mid frame", int'(dac_code), 'h3C);
      expq.push_back({2'b00, 8'hF0});
      send_byte(8'h0A, 1'b1, "R7 second byte ack");
      send_frame(8'h5A, 2'b11, 2'b00);
      bus_stop();
      check("R11 code under hi-z", int'(dac_code), 'h5A);
      check("R11 mode", int'(pd_mode), 3);

      // R3 broadcast, R6 ignored upper bits
      bus_start();
      send_byte(8'h90, 1'b1, "R3 broadcast ack");
      send_frame(8'h00, 2'b10, 2'b11);
      bus_stop();
      check("R6 code", int'(dac_code), 0);
      check("R6 mode", int'(pd_mode), 2);

      // R4 rejected addresses
      bus_start();
      send_byte(8'h98, 1'b0, "R4 foreign select nack");
      send_byte(8'h12, 1'b0, "R4 byte ignored");
      send_byte(8'h34, 1'b0, "R4 byte ignored");
      bus_stop();
      bus_start();
      send_byte(8'h9B, 1'b0, "R4 read nack");
      send_byte(8'h21, 1'b0, "R4 byte ignored");
      bus_stop();
      bus_start();
      send_byte(8'h00, 1'b0, "R4 general call nack");
      send_byte(8'h01, 1'b0, "R4 byte ignored");
      bus_stop();
      bus_start();
      send_byte(8'hF0, 1'b0, "R4 ten-bit nack");
      bus_stop();
      check("R4 code kept", int'(dac_code), 0);
      check("R4 mode kept", int'(pd_mode), 2);

      // R9 repeated START discards half frame
      bus_start();
      send_byte(8'h9A, 1'b1, "R9 address ack");
      send_byte(8'h1F, 1'b1, "R9 first byte ack");
      bus_start();
      send_byte(8'h9A, 1'b1, "R9 readdress ack");
      send_frame(8'h81, 2'b00, 2'b00);
      bus_stop();
      check("R9 code", int'(dac_code), 'h81);

      // R10 high-speed master code
      bus_start();
      send_byte(8'h09, 1'b0, "R10 hs code nack");
      check("R10 hs set", int'(hs_active), 1);
      bus_start();
      send_byte(8'h9A, 1'b1, "R10 address after Sr");
      send_frame(8'h42, 2'b01, 2'b00);
      check("R10 hs held", int'(hs_active), 1);
      bus_stop();
      check("R10 hs cleared", int'(hs_active), 0);
      check("R10 code", int'(dac_code), 'h42);

      tick(50);
      check("R8 all updates seen", expq.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule